// File: doc/BRIEF.md
# Sector Write-Lock Sequencer

This block watches the completed cycles of a parallel memory bus. Each cycle is a read or a write with a 17-bit word address; for writes, only the low data byte matters to this block. A register of eight lock bits, one for each 16K-word sector, decides which sectors may be written. The block raises a write-inhibit flag for every write cycle that lands in a locked sector. The array controller uses that flag to drop the write.

The lock bits can only change through an exact command pattern. Six reads at fixed addresses arm the sequencer. Four more cycles then either load new lock bits or read the current ones back. To load, the host writes the new byte, then writes its bitwise complement, then writes a tail cycle, then performs a closing read. To read back, the host makes an access to a select address and then reads a fixed address; that read returns the lock byte in place of array data. The two bytes that carry the setting and its complement are flagged so the array controller never stores them. Reads inside the pattern stay ordinary array reads.

Any cycle that does not fit the pattern sends the sequencer back to the start. The lock register models nonvolatile storage as a plain register that clears on reset. The bus accepts one snooped cycle whenever `cyc_valid` is high. There is no back-pressure: the snoop side has no ready signal and never stalls the bus. All outputs other than `prot_bits` are combinational, for the cycle currently on the bus.

Top module: `sector_lock_unit`

## Requirements
- R1: The sequencer arms only after six consecutive valid reads at 12555h, 1DAAAh, 01333h, 0ECCCh, 000FFh, 1FF00h, in that order.
- R2: When armed, four cycles load bits [7:0] of the first write into `prot_bits`: a write to 1DAAAh with the new byte, a write to 0ECCCh with its exact complement, a write to 0FF00h, and a read of 00000h. The new value is visible in the cycle after that closing read.
- R3: If the complement write at 0ECCCh does not carry the exact inverse of the held byte, `prot_bits` is unchanged and the sequencer returns to the start.
- R4: A wrong address, a wrong cycle type, or a seventh read where a write is expected returns the sequencer to the start. The breaking cycle is itself tested as the first step, so a read of 12555h re-arms step one at once.
- R5: `array_wr_suppress` is high for the write carrying the new byte and for the write at 0ECCCh that follows it, whether or not that write holds the correct complement. It is low for every read and every other write.
- R6: `wr_inhibit` is high exactly for valid write cycles whose address bits [16:14] select a sector n with `prot_bits[n]` = 1. Reads are never inhibited.
- R7: After reset, `prot_bits` is 00h, so every sector is writable.
- R8: When armed, an access of either type to 0ECCCh followed by a read of 1AAAAh raises `rd_override` on that read. In that cycle `rd_override_data` is {8'h00, `prot_bits`}; otherwise it is zero. A read of 00000h then closes the sequence.
- R9: Cycles with `cyc_valid` low do not advance, abort or otherwise affect the sequencer.
- R10: A write to one of the unlock addresses outside a valid armed sequence is an ordinary write: it is not suppressed and it obeys sector locking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_valid | input | 1 | A completed bus cycle is presented this clock |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| cyc_addr | input | 17 | Word address of the cycle |
| cyc_wdata_lo | input | 8 | Low data byte of a write cycle |
| wr_inhibit | output | 1 | This write targets a locked sector |
| array_wr_suppress | output | 1 | This write carries a lock byte or its complement and must not reach the array |
| rd_override | output | 1 | This read returns the lock settings instead of array data |
| rd_override_data | output | 16 | Data to return when `rd_override` is high, zero otherwise |
| prot_bits | output | 8 | Current lock bit for each sector |

## Verification
Some behaviour is checked by assertions on every clock. Suppression appears only on writes, and the override only on reads of 1AAAAh. Reads never raise the inhibit flag. The lock register holds its value unless a commit occurs. Idle cycles freeze the sequencer. A write during the read prefix, or a bad complement, sends the sequencer back to the start.

Other behaviour only the bench scenarios can show, because it depends on whole ten-cycle patterns. That includes the exact address order, the commit taking effect after the closing read, and the re-arm on a breaking read of 12555h. It also includes the result of a seventh read, and unlock addresses acting as ordinary writes once a sequence has failed.

// File: rtl/wpu_pkg.sv
package wpu_pkg;

  localparam int ADDR_W  = 17;
  localparam int DATA_W  = 16;
  localparam int SECTORS = 8;

  // Sequencer position: IDLE..P5 count the prefix reads already matched.
  typedef enum logic [3:0] {
    ST_IDLE      = 4'd0,
    ST_P1        = 4'd1,
    ST_P2        = 4'd2,
    ST_P3        = 4'd3,
    ST_P4        = 4'd4,
    ST_P5        = 4'd5,
    ST_ARMED     = 4'd6,
    ST_SET_CPL   = 4'd7,
    ST_SET_TAIL  = 4'd8,
    ST_SET_CLOSE = 4'd9,
    ST_RB_FETCH  = 4'd10,
    ST_RB_CLOSE  = 4'd11
  } seq_state_e;

  localparam logic [ADDR_W-1:0] A_SET_BYTE  = 17'h1DAAA;
  localparam logic [ADDR_W-1:0] A_SET_CPL   = 17'h0ECCC;
  localparam logic [ADDR_W-1:0] A_SET_TAIL  = 17'h0FF00;
  localparam logic [ADDR_W-1:0] A_CLOSE     = 17'h00000;
  localparam logic [ADDR_W-1:0] A_RB_SELECT = 17'h0ECCC;
  localparam logic [ADDR_W-1:0] A_RB_READ   = 17'h1AAAA;

  // Address of the prefix read expected after idx reads have matched.
  function automatic logic [ADDR_W-1:0] prefix_addr(input int idx);
    case (idx)
      0:       prefix_addr = 17'h12555;
      1:       prefix_addr = 17'h1DAAA;
      2:       prefix_addr = 17'h01333;
      3:       prefix_addr = 17'h0ECCC;
      4:       prefix_addr = 17'h000FF;
      default: prefix_addr = 17'h1FF00;
    endcase
  endfunction

endpackage

// File: rtl/wpu_seq_detect.sv
module wpu_seq_detect
  import wpu_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int PB_W = SECTORS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic            write,
  input  logic [AW-1:0]   addr,
  input  logic [PB_W-1:0] wbyte,
  output logic            suppress,
  output logic            rb_hit,
  output logic            commit,
  output logic [PB_W-1:0] commit_val
);

  seq_state_e      state, nxt;
  logic [PB_W-1:0] held;
  logic            load_hold;
  logic            is_rd, is_wr, rearm;

  assign is_rd = valid & ~write;
  assign is_wr = valid &  write;
  assign rearm = is_rd && (addr == prefix_addr(0));

  always_comb begin
    nxt       = state;
    suppress  = 1'b0;
    rb_hit    = 1'b0;
    commit    = 1'b0;
    load_hold = 1'b0;
    if (valid) begin
      // Default for any cycle that breaks the pattern: restart, re-testing it as step one.
      nxt = rearm ? ST_P1 : ST_IDLE;
      case (state)
        ST_P1, ST_P2, ST_P3, ST_P4, ST_P5: begin
          if (is_rd && addr == prefix_addr(int'(state)))
            nxt = seq_state_e'(state + 4'd1);
        end
        ST_ARMED: begin
          if (is_wr && addr == A_SET_BYTE) begin
            nxt       = ST_SET_CPL;
            suppress  = 1'b1;
            load_hold = 1'b1;
          end else if (addr == A_RB_SELECT) begin
            nxt = ST_RB_FETCH;
          end
        end
        ST_SET_CPL: begin
          if (is_wr && addr == A_SET_CPL) begin
            suppress = 1'b1;
            if (wbyte == ~held) nxt = ST_SET_TAIL;
          end
        end
        ST_SET_TAIL: begin
          if (is_wr && addr == A_SET_TAIL) nxt = ST_SET_CLOSE;
        end
        ST_SET_CLOSE: begin
          if (is_rd && addr == A_CLOSE) begin
            commit = 1'b1;
            nxt    = ST_IDLE;
          end
        end
        ST_RB_FETCH: begin
          if (is_rd && addr == A_RB_READ) begin
            rb_hit = 1'b1;
            nxt    = ST_RB_CLOSE;
          end
        end
        ST_RB_CLOSE: begin
          if (is_rd && addr == A_CLOSE) nxt = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      held  <= '0;
    end else begin
      state <= nxt;
      if (load_hold) held <= wbyte;
    end
  end

  assign commit_val = held;

  // R1: the set path is only entered from the armed state
  a_r1_set_after_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SET_CPL && $past(state) != ST_SET_CPL) |-> $past(state) == ST_ARMED);

  // R4: a write while collecting the read prefix aborts to the start
  a_r4_write_aborts_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && write && state inside {ST_IDLE, ST_P1, ST_P2, ST_P3, ST_P4, ST_P5}) |=> state == ST_IDLE);

  // R3: a wrong complement never advances towards a commit
  a_r3_bad_cpl_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SET_CPL && valid && write && wbyte != ~held) |=> state == ST_IDLE);

  // R9: idle bus cycles leave the sequencer where it is
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(state));

  // R5: suppression only ever accompanies a valid write
  a_r5_suppress_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    suppress |-> (valid && write));

  // R8: the override is only raised by a read of the read-back address
  a_r8_override_read: assert property (@(posedge clk) disable iff (!rst_n)
    rb_hit |-> (valid && !write && addr == A_RB_READ));

endmodule

// File: rtl/wpu_prot_store.sv
module wpu_prot_store #(
  parameter int PB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PB_W-1:0] load_val,
  output logic [PB_W-1:0] prot_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prot_q <= '0;
    else if (load) prot_q <= load_val;
  end

  // R2: the lock bits move only on a commit
  a_r2_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(prot_q));

endmodule

// File: rtl/wpu_sector_guard.sv
module wpu_sector_guard #(
  parameter int SECTORS = 8,
  localparam int SEC_W  = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
  input  logic               valid,
  input  logic               write,
  input  logic [SEC_W-1:0]   sec_idx,
  input  logic [SECTORS-1:0] prot,
  output logic               inhibit
);

  logic [SECTORS-1:0] hit;

  for (genvar s = 0; s < SECTORS; s++) begin : g_sector
    assign hit[s] = prot[s] && (sec_idx == SEC_W'(s));
  end

  assign inhibit = valid && write && (|hit);

endmodule

// File: rtl/sector_lock_unit.sv
module sector_lock_unit
  import wpu_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int DW  = DATA_W,
  parameter int NSEC = SECTORS,
  localparam int SEC_W = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_valid,
  input  logic            cyc_write,
  input  logic [AW-1:0]   cyc_addr,
  input  logic [NSEC-1:0] cyc_wdata_lo,
  output logic            wr_inhibit,
  output logic            array_wr_suppress,
  output logic            rd_override,
  output logic [DW-1:0]   rd_override_data,
  output logic [NSEC-1:0] prot_bits
);

  logic            commit;
  logic [NSEC-1:0] commit_val;

  wpu_seq_detect #(.AW(AW), .PB_W(NSEC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (cyc_valid),
    .write      (cyc_write),
    .addr       (cyc_addr),
    .wbyte      (cyc_wdata_lo),
    .suppress   (array_wr_suppress),
    .rb_hit     (rd_override),
    .commit     (commit),
    .commit_val (commit_val)
  );

  wpu_prot_store #(.PB_W(NSEC)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (commit),
    .load_val (commit_val),
    .prot_q   (prot_bits)
  );

  wpu_sector_guard #(.SECTORS(NSEC)) u_guard (
    .valid   (cyc_valid),
    .write   (cyc_write),
    .sec_idx (cyc_addr[AW-1 -: SEC_W]),
    .prot    (prot_bits),
    .inhibit (wr_inhibit)
  );

  assign rd_override_data = rd_override ? DW'(prot_bits) : '0;

  // R6: reads are never inhibited
  a_r6_reads_free: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_write) |-> !wr_inhibit);

  // R8: override data is zero whenever no override is signalled
  a_r8_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_override |-> (rd_override_data == '0));

endmodule

// File: tb/sector_lock_unit_test.sv
module sector_lock_unit_test;

  typedef struct packed {
    logic        w;
    logic [16:0] a;
    logic [7:0]  d;
    logic        inh;
    logic        sup;
    logic        ovr;
    logic [7:0]  prot;   // expected lock bits after the cycle
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t rd(logic [16:0] a, logic [7:0] p, logic [3:0] r);
    return '{w:1'b0, a:a, d:8'h00, inh:1'b0, sup:1'b0, ovr:1'b0, prot:p, req:r};
  endfunction
  function automatic vec_t rdo(logic [16:0] a, logic [7:0] p, logic [3:0] r);
    return '{w:1'b0, a:a, d:8'h00, inh:1'b0, sup:1'b0, ovr:1'b1, prot:p, req:r};
  endfunction
  function automatic vec_t wr(logic [16:0] a, logic [7:0] d, logic inh, logic sup,
                              logic [7:0] p, logic [3:0] r);
    return '{w:1'b1, a:a, d:d, inh:inh, sup:sup, ovr:1'b0, prot:p, req:r};
  endfunction

  localparam int NV = 58;
  localparam vec_t TBL [NV] = '{
    // R1 R2 R5: arm and lock sectors 3 and 4 (byte 18h)
    rd(17'h12555, 8'h00, 4'd1), rd(17'h1DAAA, 8'h00, 4'd1), rd(17'h01333, 8'h00, 4'd1),
    rd(17'h0ECCC, 8'h00, 4'd1), rd(17'h000FF, 8'h00, 4'd1), rd(17'h1FF00, 8'h00, 4'd1),
    wr(17'h1DAAA, 8'h18, 1'b0, 1'b1, 8'h00, 4'd5),
    wr(17'h0ECCC, 8'hE7, 1'b0, 1'b1, 8'h00, 4'd5),
    wr(17'h0FF00, 8'h00, 1'b0, 1'b0, 8'h00, 4'd2),
    rd(17'h00000, 8'h18, 4'd2),
    // R6: sector decode from address bits [16:14]
    wr(17'h0C000, 8'h00, 1'b1, 1'b0, 8'h18, 4'd6),
    wr(17'h13FFF, 8'h00, 1'b1, 1'b0, 8'h18, 4'd6),
    wr(17'h14000, 8'h00, 1'b0, 1'b0, 8'h18, 4'd6),
    wr(17'h0BFFF, 8'h00, 1'b0, 1'b0, 8'h18, 4'd6),
    rd(17'h0C000, 8'h18, 4'd6),
    // R8: read-back
    rd(17'h12555, 8'h18, 4'd8), rd(17'h1DAAA, 8'h18, 4'd8), rd(17'h01333, 8'h18, 4'd8),
    rd(17'h0ECCC, 8'h18, 4'd8), rd(17'h000FF, 8'h18, 4'd8), rd(17'h1FF00, 8'h18, 4'd8),
    rd(17'h0ECCC, 8'h18, 4'd8),
    rdo(17'h1AAAA, 8'h18, 4'd8),
    rd(17'h00000, 8'h18, 4'd8),
    // R3: wrong complement leaves settings, restarts
    rd(17'h12555, 8'h18, 4'd3), rd(17'h1DAAA, 8'h18, 4'd3), rd(17'h01333, 8'h18, 4'd3),
    rd(17'h0ECCC, 8'h18, 4'd3), rd(17'h000FF, 8'h18, 4'd3), rd(17'h1FF00, 8'h18, 4'd3),
    wr(17'h1DAAA, 8'hFF, 1'b0, 1'b1, 8'h18, 4'd3),
    wr(17'h0ECCC, 8'h01, 1'b1, 1'b1, 8'h18, 4'd3),
    wr(17'h0FF00, 8'h00, 1'b1, 1'b0, 8'h18, 4'd3),
    rd(17'h00000, 8'h18, 4'd3),
    // R4 R10: seventh read aborts, unlock addresses become ordinary writes
    rd(17'h12555, 8'h18, 4'd4), rd(17'h1DAAA, 8'h18, 4'd4), rd(17'h01333, 8'h18, 4'd4),
    rd(17'h0ECCC, 8'h18, 4'd4), rd(17'h000FF, 8'h18, 4'd4), rd(17'h1FF00, 8'h18, 4'd4),
    rd(17'h1FF00, 8'h18, 4'd4),
    wr(17'h1DAAA, 8'hFF, 1'b0, 1'b0, 8'h18, 4'd10),
    wr(17'h0ECCC, 8'h00, 1'b1, 1'b0, 8'h18, 4'd10),
    // R4: breaking read of 12555h re-arms, then clear all locks
    rd(17'h12555, 8'h18, 4'd4), rd(17'h1DAAA, 8'h18, 4'd4), rd(17'h12555, 8'h18, 4'd4),
    rd(17'h1DAAA, 8'h18, 4'd4), rd(17'h01333, 8'h18, 4'd4), rd(17'h0ECCC, 8'h18, 4'd4),
    rd(17'h000FF, 8'h18, 4'd4), rd(17'h1FF00, 8'h18, 4'd4),
    wr(17'h1DAAA, 8'h00, 1'b0, 1'b1, 8'h18, 4'd4),
    wr(17'h0ECCC, 8'hFF, 1'b1, 1'b1, 8'h18, 4'd4),
    wr(17'h0FF00, 8'h00, 1'b1, 1'b0, 8'h18, 4'd4),
    rd(17'h00000, 8'h00, 4'd4),
    wr(17'h0C000, 8'h00, 1'b0, 1'b0, 8'h00, 4'd6),
    // R4: wrong cycle type in the prefix is an ordinary write
    rd(17'h12555, 8'h00, 4'd4),
    wr(17'h1DAAA, 8'h00, 1'b0, 1'b0, 8'h00, 4'd4)
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0, cyc_write = 1'b0;
  logic [16:0] cyc_addr = '0;
  logic [7:0]  cyc_wdata_lo = '0;
  logic        wr_inhibit, array_wr_suppress, rd_override;
  logic [15:0] rd_override_data;
  logic [7:0]  prot_bits;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sector_lock_unit uut (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
    .cyc_addr(cyc_addr), .cyc_wdata_lo(cyc_wdata_lo), .wr_inhibit(wr_inhibit),
    .array_wr_suppress(array_wr_suppress), .rd_override(rd_override),
    .rd_override_data(rd_override_data), .prot_bits(prot_bits)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Presents one cycle; checks combinational outputs, then lock bits after the edge.
  task automatic cycle(logic v, logic w, logic [16:0] a, logic [7:0] d,
                       logic ei, logic es, logic eo, logic [7:0] ep, string tag);
    @(negedge clk);
    cyc_valid = v; cyc_write = w; cyc_addr = a; cyc_wdata_lo = d;
    #1;
    chk({tag, " wr_inhibit"}, 32'(wr_inhibit), 32'(ei));
    chk({tag, " suppress"}, 32'(array_wr_suppress), 32'(es));
    chk({tag, " override"}, 32'(rd_override), 32'(eo));
    chk({tag, " override_data"}, 32'(rd_override_data), eo ? 32'(prot_bits) : 32'h0);
    @(posedge clk); #1;
    chk({tag, " prot_bits"}, 32'(prot_bits), 32'(ep));
  endtask

  task automatic idle();
    @(negedge clk);
    cyc_valid = 1'b0; cyc_write = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 reset prot", 32'(prot_bits), 32'h0);
    chk("R7 reset suppress", 32'(array_wr_suppress), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 after release", 32'(prot_bits), 32'h0);

    for (int i = 0; i < NV; i++) begin
      cycle(1'b1, TBL[i].w, TBL[i].a, TBL[i].d, TBL[i].inh, TBL[i].sup,
            TBL[i].ovr, TBL[i].prot, $sformatf("R%0d vec%0d", TBL[i].req, i));
    end

    // R9: idle cycles interleaved in a full set sequence (byte 81h)
    cycle(1'b1, 1'b0, 17'h12555, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, "R9 p1");
    idle(); idle();
    cycle(1'b1, 1'b0, 17'h1DAAA, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, "R9 p2");
    cycle(1'b1, 1'b0, 17'h01333, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, "R9 p3");
    idle();
    cycle(1'b1, 1'b0, 17'h0ECCC, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, "R9 p4");
    cycle(1'b1, 1'b0, 17'h000FF, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, "R9 p5");
    cycle(1'b1, 1'b0, 17'h1FF00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, "R9 p6");
    // R9: a write presented with valid low is not seen
    cycle(1'b0, 1'b1, 17'h0C000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, "R9 invalid write");
    cycle(1'b1, 1'b1, 17'h1DAAA, 8'h81, 1'b0, 1'b1, 1'b0, 8'h00, "R9 byte");
    idle();
    cycle(1'b1, 1'b1, 17'h0ECCC, 8'h7E, 1'b0, 1'b1, 1'b0, 8'h00, "R9 cpl");
    cycle(1'b1, 1'b1, 17'h0FF00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, "R9 tail");
    cycle(1'b1, 1'b0, 17'h00000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h81, "R9 close");
    // R6: sectors 0 and 7 locked, 1 free
    cycle(1'b1, 1'b1, 17'h00010, 8'h00, 1'b1, 1'b0, 1'b0, 8'h81, "R6 sector0");
    cycle(1'b1, 1'b1, 17'h1FFFF, 8'h00, 1'b1, 1'b0, 1'b0, 8'h81, "R6 sector7");
    cycle(1'b1, 1'b1, 17'h04000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h81, "R6 sector1");
    // R8: read-back selected by a write access to 0ECCCh
    cycle(1'b1, 1'b0, 17'h12555, 8'h00, 1'b0, 1'b0, 1'b0, 8'h81, "R8 p1");
    cycle(1'b1, 1'b0, 17'h1DAAA, 8'h00, 1'b0, 1'b0, 1'b0, 8'h81, "R8 p2");
    cycle(1'b1, 1'b0, 17'h01333, 8'h00, 1'b0, 1'b0, 1'b0, 8'h81, "R8 p3");
    cycle(1'b1, 1'b0, 17'h0ECCC, 8'h00, 1'b0, 1'b0, 1'b0, 8'h81, "R8 p4");
    cycle(1'b1, 1'b0, 17'h000FF, 8'h00, 1'b0, 1'b0, 1'b0, 8'h81, "R8 p5");
    cycle(1'b1, 1'b0, 17'h1FF00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h81, "R8 p6");
    cycle(1'b1, 1'b1, 17'h0ECCC, 8'h55, 1'b0, 1'b0, 1'b0, 8'h81, "R8 select write");
    cycle(1'b1, 1'b0, 17'h1AAAA, 8'h00, 1'b0, 1'b0, 1'b1, 8'h81, "R8 fetch");
    chk("R8 data word", 32'(rd_override_data), 32'h0);
    // R7: reset returns the model storage to its default
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R7 reset mid-run", 32'(prot_bits), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    cycle(1'b1, 1'b1, 17'h00010, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, "R7 sector0 free");

    finish_run();
  end

endmodule